// File: doc/BRIEF.md
# Elapsed-Time Counter with Interval Alarm

This block keeps a running time of day from a one-cycle tick that arrives 128 times a second. Four registers hold 128ths of a second, seconds, minutes and hours. Each register rolls over at its own limit and carries into the next. A control bit starts and stops the whole cascade. Software can load any time register through a small register port, and that load takes effect at once.

Next to the cascade sits an interval counter. It counts advances of one chosen unit: 128ths, seconds, minutes or hours. When the count equals a programmed value, it raises a sticky flag that is also driven on the interrupt output. The counter then either restarts from zero (auto-reload) or stops and drops its own enable (single-shot).

Software reaches every register through one address bus. A write takes effect on the clock edge. A read is combinational and follows the address in the same cycle.

Top module: `elapsed_timer`

## Requirements
- R1: After reset every time register, the interval value and the interval count read 0. The control register (address 0) reads 0x40 and `irq` is low.
- R2: While control bit 0 (run) is 0, ticks leave all four time registers unchanged.
- R3: With run set, each tick advances the 128ths register (address 1). On the tick where it holds 127, it returns to 0 and the seconds register (address 2) advances by one.
- R4: Seconds (address 2) and minutes (address 3) go from 59 to 0 and carry into the next register. Hours (address 4) go from 23 to 0. A single tick can ripple through all four registers.
- R5: A write to a time register loads the written value on that clock edge. It replaces any tick-driven change to that register in the same cycle.
- R6: Control bits 5:4 pick what the interval counter counts: 0 = advances of the 128ths register, 1 = seconds, 2 = minutes, 3 = hours. The counter advances only while control bit 1 is set, and not in a cycle that writes the control register. Its value reads at address 6, and writes to address 6 are ignored.
- R7: When the interval count would reach the value at address 5, control bit 2 and `irq` go high and the count returns to 0. With control bit 3 at 0, counting then continues.
- R8: With control bit 3 at 1, a match also clears control bit 1. The count then stays at 0 until software sets bit 1 again.
- R9: Control bit 2 (`irq`) stays set until software writes the control register with bit 2 at 0. A control write loads bit 2 from the written data.
- R10: A control write with bit 1 at 0 clears the interval count. Control bit 6 always reads 1 and bit 7 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse, 128 per second |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interval flag (control bit 2) |

## Verification
The assertions assume that software writes only in-range values into the time registers. They also assume that `tick` is a clean single-cycle pulse that the carry properties can pair with the register values from the same cycle. Several properties hold only when no register write lands in that cycle, so their antecedents exclude a write to the register concerned. The directed stimulus loads only legal times and places each rollover on a cycle with no write, so it stays inside these assumptions. The random phase writes arbitrary bytes, and only the reference comparison, which follows the same rules, judges those cycles.

// File: rtl/elt_pkg.sv
package elt_pkg;
    localparam int DW        = 8;
    localparam int AW        = 3;
    localparam int NUM_UNITS = 4;

    localparam logic [AW-1:0] A_CTRL   = 3'd0;
    localparam logic [AW-1:0] A_FRAC   = 3'd1;
    localparam logic [AW-1:0] A_SEC    = 3'd2;
    localparam logic [AW-1:0] A_MIN    = 3'd3;
    localparam logic [AW-1:0] A_HOUR   = 3'd4;
    localparam logic [AW-1:0] A_TARGET = 3'd5;
    localparam logic [AW-1:0] A_COUNT  = 3'd6;

    localparam int C_RUN  = 0;
    localparam int C_IEN  = 1;
    localparam int C_FLAG = 2;
    localparam int C_ONE  = 3;
    localparam int C_BASE = 4;

    typedef struct packed {
        logic          run;
        logic          single;
        logic [1:0]    base;
        logic [DW-1:0] target;
    } ctl_t;

    typedef struct packed {
        logic          en;
        logic          flag;
        logic [DW-1:0] cnt;
    } ivl_t;
endpackage

// File: rtl/elt_unit.sv
module elt_unit #(
    parameter int W     = 8,
    parameter int LIMIT = 60
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step_i,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic [W-1:0] val_o,
    output logic         wrap_o
);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] val_d, val_q;

    assign wrap_o = step_i && (val_q >= LAST);
    assign val_o  = val_q;

    always_comb begin
        val_d = val_q;
        if (load_i) begin
            val_d = load_val_i;
        end else if (step_i) begin
            val_d = wrap_o ? '0 : val_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end
endmodule

// File: rtl/elt_interval.sv
module elt_interval
    import elt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_UNITS-1:0] evt_i,
    input  logic [1:0]           base_i,
    input  logic                 single_i,
    input  logic [DW-1:0]        target_i,
    input  logic                 ctrl_wr_i,
    input  logic                 wr_en_bit_i,
    input  logic                 wr_flag_bit_i,
    output logic                 en_o,
    output logic                 flag_o,
    output logic                 hit_o,
    output logic [DW-1:0]        cnt_o
);
    ivl_t          st_d, st_q;
    logic          adv;
    logic [DW-1:0] cnt_inc;

    assign adv     = st_q.en && !ctrl_wr_i && evt_i[base_i];
    assign cnt_inc = st_q.cnt + 1'b1;
    assign hit_o   = adv && (cnt_inc == target_i);

    always_comb begin
        st_d = st_q;
        if (hit_o) begin
            st_d.cnt  = '0;
            st_d.flag = 1'b1;
            st_d.en   = !single_i;
        end else if (adv) begin
            st_d.cnt = cnt_inc;
        end
        if (ctrl_wr_i) begin
            st_d.en   = wr_en_bit_i;
            st_d.flag = wr_flag_bit_i;
            if (!wr_en_bit_i) st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o   = st_q.en;
    assign flag_o = st_q.flag;
    assign cnt_o  = st_q.cnt;
endmodule

// File: rtl/elapsed_timer.sv
module elapsed_timer
    import elt_pkg::*;
#(
    parameter int TICKS_PER_SEC = 128,
    parameter int SEC_PER_MIN   = 60,
    parameter int MIN_PER_HOUR  = 60,
    parameter int HOUR_PER_DAY  = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    output logic          irq
);
    ctl_t                           ctl_d, ctl_q;
    logic                           ctrl_wr;
    logic                           run_w, single_w;
    logic [NUM_UNITS-1:0]           step, wrap;
    logic [NUM_UNITS-1:0][DW-1:0]   unit_val;
    logic                           ival_en, ival_flag, ival_hit;
    logic [DW-1:0]                  ival_cnt;

    assign ctrl_wr  = wr_en && (addr == A_CTRL);
    assign run_w    = ctl_q.run;
    assign single_w = ctl_q.single;
    assign step[0]  = run_w && tick;

    generate
        for (genvar g = 0; g < NUM_UNITS; g++) begin : g_unit
            localparam int LIM = (g == 0) ? TICKS_PER_SEC :
                                 (g == 1) ? SEC_PER_MIN   :
                                 (g == 2) ? MIN_PER_HOUR  : HOUR_PER_DAY;
            localparam logic [AW-1:0] MY_ADDR = AW'(g + 1);
            if (g > 0) begin : g_chain
                assign step[g] = wrap[g-1];
            end
            elt_unit #(.W(DW), .LIMIT(LIM)) u_unit (
                .clk        (clk),
                .rst_n      (rst_n),
                .step_i     (step[g]),
                .load_i     (wr_en && (addr == MY_ADDR)),
                .load_val_i (wr_data),
                .val_o      (unit_val[g]),
                .wrap_o     (wrap[g])
            );
        end
    endgenerate

    elt_interval u_ival (
        .clk           (clk),
        .rst_n         (rst_n),
        .evt_i         (step),
        .base_i        (ctl_q.base),
        .single_i      (ctl_q.single),
        .target_i      (ctl_q.target),
        .ctrl_wr_i     (ctrl_wr),
        .wr_en_bit_i   (wr_data[C_IEN]),
        .wr_flag_bit_i (wr_data[C_FLAG]),
        .en_o          (ival_en),
        .flag_o        (ival_flag),
        .hit_o         (ival_hit),
        .cnt_o         (ival_cnt)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ctrl_wr) begin
            ctl_d.run    = wr_data[C_RUN];
            ctl_d.single = wr_data[C_ONE];
            ctl_d.base   = wr_data[C_BASE+1:C_BASE];
        end
        if (wr_en && (addr == A_TARGET)) ctl_d.target = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        case (addr)
            A_CTRL:   rd_data = {1'b0, 1'b1, ctl_q.base, ctl_q.single,
                                 ival_flag, ival_en, ctl_q.run};
            A_FRAC:   rd_data = unit_val[0];
            A_SEC:    rd_data = unit_val[1];
            A_MIN:    rd_data = unit_val[2];
            A_HOUR:   rd_data = unit_val[3];
            A_TARGET: rd_data = ctl_q.target;
            A_COUNT:  rd_data = ival_cnt;
            default:  rd_data = '0;
        endcase
    end

    assign irq = ival_flag;
endmodule

// File: rtl/elt_checker.sv
module elt_checker
    import elt_pkg::*;
(
    input logic                         clk,
    input logic                         rst_n,
    input logic                         tick,
    input logic                         wr_en,
    input logic [AW-1:0]                addr,
    input logic [DW-1:0]                wr_data,
    input logic [DW-1:0]                rd_data,
    input logic                         irq,
    input logic                         run_w,
    input logic                         single_w,
    input logic [NUM_UNITS-1:0]         wrap,
    input logic [NUM_UNITS-1:0][DW-1:0] unit_val,
    input logic                         ival_en,
    input logic                         ival_hit,
    input logic [DW-1:0]                ival_cnt
);
    logic time_wr;
    assign time_wr = wr_en && (addr >= A_FRAC) && (addr <= A_HOUR);

    // R2
    hold_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_w && !time_wr) |=> $stable(unit_val));

    // R3
    frac_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_w && tick && unit_val[0] == 8'd127 && !time_wr) |=> (unit_val[0] == 8'd0));

    // R4
    day_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap[3] && !time_wr) |=> (unit_val[3] == 8'd0 && unit_val[2] == 8'd0));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(wr_en && addr == A_CTRL)) |=> irq);

    // R8
    single_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ival_hit && single_w) |=> (!ival_en && ival_cnt == '0));

    // R10
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTRL && !wr_data[C_IEN]) |=> (ival_cnt == '0));

    // R10
    ctrl_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> (rd_data[6] && !rd_data[7]));
endmodule

bind elapsed_timer elt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .irq      (irq),
    .run_w    (run_w),
    .single_w (single_w),
    .wrap     (wrap),
    .unit_val (unit_val),
    .ival_en  (ival_en),
    .ival_hit (ival_hit),
    .ival_cnt (ival_cnt)
);

// File: tb/tb_elapsed_timer.sv
`timescale 1ns/1ps
module tb_elapsed_timer;
    logic       clk = 0, rst_n = 0, tick = 0, wr_en = 0;
    logic [2:0] addr = 0;
    logic [7:0] wr_data = 0;
    wire  [7:0] rd_data;
    wire        irq;

    always #2.5 clk = ~clk;

    elapsed_timer dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
        .addr(addr), .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    int n_checks = 0, n_fail = 0;
    bit done = 0;

    // behavioural reference
    int m_val[4];
    int m_target, m_cnt, m_base;
    bit m_run, m_en, m_flag, m_single;

    function automatic int lim(int i);
        return (i == 0) ? 128 : (i == 3) ? 24 : 60;
    endfunction

    function automatic int m_read(int a);
        case (a)
            0: return 64 + m_base * 16 + m_single * 8 + m_flag * 4 + m_en * 2 + m_run;
            1, 2, 3, 4: return m_val[a-1];
            5: return m_target;
            6: return m_cnt;
            default: return 0;
        endcase
    endfunction

    function automatic string tag_of(int a);
        case (a)
            0: return "R7";
            1: return "R3";
            2, 3, 4: return "R4";
            5: return "R5";
            6: return "R6";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        bit stp[5];
        int nv[4];
        bit cw, ev;
        if (!rst_n) begin
            foreach (m_val[i]) m_val[i] = 0;
            m_target = 0; m_cnt = 0; m_base = 0;
            m_run = 0; m_en = 0; m_flag = 0; m_single = 0;
        end else begin
            stp[0] = m_run && tick;
            for (int i = 0; i < 4; i++) begin
                nv[i] = m_val[i];
                stp[i+1] = 0;
                if (stp[i]) begin
                    if (m_val[i] >= lim(i) - 1) begin nv[i] = 0; stp[i+1] = 1; end
                    else nv[i] = m_val[i] + 1;
                end
            end
            if (wr_en && addr >= 1 && addr <= 4) nv[addr-1] = wr_data;
            cw = wr_en && addr == 0;
            ev = m_en && !cw && stp[m_base];
            if (ev) begin
                if (((m_cnt + 1) % 256) == m_target) begin
                    m_flag = 1; m_cnt = 0;
                    if (m_single) m_en = 0;
                end else m_cnt = m_cnt + 1;
            end
            if (cw) begin
                m_run = wr_data[0]; m_en = wr_data[1]; m_flag = wr_data[2];
                m_single = wr_data[3]; m_base = wr_data[5:4];
                if (!wr_data[1]) m_cnt = 0;
            end
            if (wr_en && addr == 5) m_target = wr_data;
            m_val = nv;
        end
    end

    task automatic chk(string tag, int act, int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(bit we, int a, int d, bit t);
        @(negedge clk);
        if (rst_n) begin
            chk(tag_of(addr), rd_data, m_read(addr));
            chk("R9", irq, m_flag);
        end
        wr_en = we; addr = 3'(a); wr_data = 8'(d); tick = t;
    endtask

    task automatic wr(int a, int d); cyc(1, a, d, 0); endtask
    task automatic ticks(int n, int a); repeat (n) cyc(0, a, 0, 1); endtask
    task automatic rd(int a, int exp, string tag);
        cyc(0, a, 0, 0);
        @(posedge clk); #1;
        chk(tag, rd_data, exp);
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(0, 'h40, "R1");
        for (int a = 1; a <= 6; a++) rd(a, 0, "R1");
        chk("R1", irq, 0);
        // R2 stopped clock ignores ticks
        ticks(10, 1);
        rd(1, 0, "R2");
        // R3 counting and 128ths rollover
        wr(0, 'h01);
        ticks(5, 1);
        rd(1, 5, "R3");
        wr(1, 126);
        ticks(2, 1);
        rd(1, 0, "R3");
        rd(2, 1, "R3");
        // R4 full-day ripple
        wr(1, 127); wr(2, 59); wr(3, 59); wr(4, 23);
        ticks(1, 4);
        rd(4, 0, "R4"); rd(3, 0, "R4"); rd(2, 0, "R4"); rd(1, 0, "R4");
        wr(4, 5); wr(3, 10); wr(2, 59); wr(1, 127);
        ticks(1, 2);
        rd(3, 11, "R4"); rd(2, 0, "R4"); rd(4, 5, "R4");
        // R5 write beats same-cycle tick
        cyc(1, 1, 'h20, 1);
        rd(1, 'h20, "R5");
        // R6 / R7 auto-reload on 128ths
        wr(5, 3); wr(0, 'h03);
        ticks(2, 6);
        rd(6, 2, "R6");
        ticks(1, 6);
        rd(6, 0, "R7");
        chk("R7", irq, 1);
        rd(0, 'h47, "R7");
        ticks(2, 6);
        rd(6, 2, "R7");
        chk("R9", irq, 1);
        wr(0, 'h03);
        rd(0, 'h43, "R9");
        chk("R9", irq, 0);
        // R8 single-shot on seconds
        wr(0, 'h01); wr(5, 2); wr(1, 120); wr(0, 'h1B);
        ticks(8, 6);
        rd(6, 1, "R6");
        ticks(128, 6);
        rd(0, 'h5D, "R8");
        rd(6, 0, "R8");
        ticks(300, 6);
        rd(6, 0, "R8");
        chk("R8", irq, 1);
        // R6 minutes and hours timebases
        wr(0, 'h01); wr(5, 2); wr(1, 127); wr(2, 59); wr(0, 'h23);
        ticks(1, 6);
        rd(6, 1, "R6");
        wr(0, 'h01); wr(5, 1); wr(1, 127); wr(2, 59); wr(3, 59); wr(0, 'h33);
        ticks(1, 0);
        rd(0, 'h77, "R6");
        wr(6, 'h55);
        rd(6, 0, "R6");
        // R10 disable clears count, fixed control bits
        wr(0, 'h01); wr(5, 200); wr(0, 'h03);
        ticks(5, 6);
        rd(6, 5, "R10");
        wr(0, 'h81);
        rd(6, 0, "R10");
        rd(0, 'h41, "R10");
        // mixed random traffic against the reference
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 8 == 0) cyc(1, $urandom % 8, $urandom % 256, $urandom % 2);
            else                   cyc(0, $urandom % 8, 0, $urandom % 2);
        end
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        done = 1;
        summary();
        $finish;
    end
endmodule